// File: doc/BRIEF.md
# Compare and Conditional Branch Unit

This unit sits beside the datapath of a small 8-bit processor. When a compare is issued it takes a source register and a second operand, subtracts them, and keeps the resulting zero, carry, sign and overflow flags. The subtraction result itself is discarded. The second operand is either another register or one of four fixed constants. The arithmetic unit can also load the flag register directly after an add or subtract. As a result, an add that overflows can be tested later with the same "less" condition that a compare produces.

On a jump, the unit reads a condition code and decides whether the branch is taken, using either unsigned or signed ordering. It then produces the address of the next instruction. That address is one of three things: an absolute 16-bit target, a target computed from a signed 8-bit displacement, or the sequential address just past the jump and its operand bytes.

Top module: `cmp_branch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the flags (z, c, n, v), `next_pc`, `next_pc_valid` and `jmp_taken` all clear to zero.
- R2: `cmp_src_sel` and `cmp_opnd_sel` pick registers a..d as codes 0..3, where register k is `regs_flat[8k+7:8k]`. When `cmp_opnd_const` is 1, `cmp_opnd_sel` instead picks a constant: code 0 is 0x00, code 1 is 0x01, code 2 is -1 (0xFF) and code 3 is 255 (0xFF).
- R3: A compare computes source minus operand. On the next edge it sets z (result is zero), c (unsigned borrow, i.e. source < operand), n (bit 7 of the result) and v (two's-complement overflow). It also latches `sgn_mode`.
- R4: `alu_upd` loads the flags and `sgn_mode` from the ALU flag inputs. If a compare is issued in the same cycle, the compare takes priority.
- R5: When neither a compare nor an ALU update is issued, the flags hold their value.
- R6: Condition codes in unsigned mode: 1 eq (z), 2 ne (!z), 3 lt (c), 4 le (c|z), 5 gt (!c & !z), 6 ge (!c).
- R7: In signed mode, lt is n^v, le is lt|z, gt is !lt & !z, and ge is !lt. Codes 1 and 2 are unchanged.
- R8: Condition code 0 is always taken. Code 7 is never taken.
- R9: A taken absolute jump (`jmp_rel` = 0) sets `next_pc` to `jmp_target`.
- R10: A taken relative jump sets `next_pc` to pc + 2 + sign-extended `jmp_offset`, modulo 2^16.
- R11: A jump that is not taken sets `next_pc` to pc + 3 for the absolute form and pc + 2 for the relative form, modulo 2^16.
- R12: `next_pc_valid` and `jmp_taken` are registered. Each is high for exactly the one cycle after a `jmp_valid` cycle, and `jmp_taken` is never high without `next_pc_valid`. A jump uses the flags as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| regs_flat | input | 32 | Registers a..d, a in the low byte |
| cmp_valid | input | 1 | Issue a compare this cycle |
| cmp_src_sel | input | 2 | Source register code |
| cmp_opnd_const | input | 1 | Second operand is a constant |
| cmp_opnd_sel | input | 2 | Register or constant code |
| sgn_mode | input | 1 | Signed ordering for the flags being written |
| alu_upd | input | 1 | Load flags from the ALU |
| alu_z | input | 1 | ALU zero |
| alu_c | input | 1 | ALU carry/borrow |
| alu_n | input | 1 | ALU sign |
| alu_v | input | 1 | ALU overflow |
| jmp_valid | input | 1 | Evaluate a jump this cycle |
| jmp_cond | input | 3 | Condition code |
| jmp_rel | input | 1 | 1 = relative form |
| pc | input | 16 | Address of the jump opcode |
| jmp_target | input | 16 | Absolute target |
| jmp_offset | input | 8 | Signed displacement |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry/borrow flag |
| flag_n | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |
| next_pc | output | 16 | Next instruction address |
| next_pc_valid | output | 1 | next_pc is fresh this cycle |
| jmp_taken | output | 1 | Jump was taken |

## Verification
The assertions check a set of rules on every cycle. `next_pc_valid` tracks `jmp_valid` with one cycle of delay, a taken flag never appears without a valid, and an idle cycle leaves the flags unchanged. A compare of equal operands sets zero. An untaken jump lands at the sequential address, and codes 0 and 7 always and never branch respectively. Other behaviour can only be shown by the bench's scenarios. That includes the correct decision for each relation, the mode-dependent signed/unsigned ordering near the 0x7F/0x80 boundary, the constant decoding, the priority of a compare over an ALU update, and relative targets that wrap backwards.

// File: rtl/cbu_pkg.sv
// Shared types for the compare and branch unit.
// Assumes condition codes are 3 bits wide and fixed in the encoding below.
package cbu_pkg;

    typedef enum logic [2:0] {
        CND_ALWAYS = 3'd0,
        CND_EQ     = 3'd1,
        CND_NE     = 3'd2,
        CND_LT     = 3'd3,
        CND_LE     = 3'd4,
        CND_GT     = 3'd5,
        CND_GE     = 3'd6,
        CND_NEVER  = 3'd7
    } cond_e;

    typedef struct packed {
        logic sgn;
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

endpackage

// File: rtl/cbu_flag_gen.sv
// Flag generator: selects compare operands, subtracts them and holds flags.
// Assumes NREG >= 4 so the operand code can also address the four constants.
module cbu_flag_gen
    import cbu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG*DATA_W-1:0] regs_flat,
    input  logic                   cmp_valid,
    input  logic [SEL_W-1:0]       cmp_src_sel,
    input  logic                   cmp_opnd_const,
    input  logic [SEL_W-1:0]       cmp_opnd_sel,
    input  logic                   sgn_mode,
    input  logic                   alu_upd,
    input  logic                   alu_z,
    input  logic                   alu_c,
    input  logic                   alu_n,
    input  logic                   alu_v,
    output flags_t                 flags_q
);

    logic [DATA_W-1:0] reg_arr [NREG];
    logic [DATA_W-1:0] opa, opb, konst;
    logic [DATA_W:0]   diff;
    flags_t            cmp_flags;

    // Unpack the flat register bus, one byte lane per register.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_unpack
        assign reg_arr[gi] = regs_flat[gi*DATA_W +: DATA_W];
    end

    // Decode the fixed constant selected by the low two operand bits.
    always_comb begin
        case (cmp_opnd_sel[1:0])
            2'd0:    konst = '0;
            2'd1:    konst = DATA_W'(1);
            default: konst = '1;
        endcase
    end

    // Pick operands and form the borrow-extended difference and its flags.
    always_comb begin
        opa            = reg_arr[cmp_src_sel];
        opb            = cmp_opnd_const ? konst : reg_arr[cmp_opnd_sel];
        diff           = {1'b0, opa} - {1'b0, opb};
        cmp_flags.sgn  = sgn_mode;
        cmp_flags.z    = (diff[DATA_W-1:0] == '0);
        cmp_flags.c    = diff[DATA_W];
        cmp_flags.n    = diff[DATA_W-1];
        cmp_flags.v    = (opa[DATA_W-1] != opb[DATA_W-1]) &&
                         (diff[DATA_W-1] != opa[DATA_W-1]);
    end

    // Flag register: compare first, then ALU load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (cmp_valid) begin
            flags_q <= cmp_flags;
        end else if (alu_upd) begin
            flags_q <= '{sgn: sgn_mode, z: alu_z, c: alu_c, n: alu_n, v: alu_v};
        end
    end

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !alu_upd) |=> $stable(flags_q));

    // R3
    equal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && opa == opb) |=> (flags_q.z && !flags_q.c));

endmodule

// File: rtl/cbu_cond_eval.sv
// Condition evaluator: turns stored flags and a condition code into taken.
// Assumes flags reflect the most recent compare or ALU update.
module cbu_cond_eval
    import cbu_pkg::*;
(
    input  flags_t     flags,
    input  logic [2:0] cond,
    output logic       taken
);

    logic lt_u, lt_s, lt;

    // Choose the "less" relation for the stored mode and decode the code.
    always_comb begin
        lt_u = flags.c;
        lt_s = flags.n ^ flags.v;
        lt   = flags.sgn ? lt_s : lt_u;
        case (cond_e'(cond))
            CND_ALWAYS: taken = 1'b1;
            CND_EQ:     taken = flags.z;
            CND_NE:     taken = !flags.z;
            CND_LT:     taken = lt;
            CND_LE:     taken = lt || flags.z;
            CND_GT:     taken = !lt && !flags.z;
            CND_GE:     taken = !lt;
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbu_next_pc.sv
// Next-address selector: registers the sequential, absolute or relative target.
// Assumes absolute jumps occupy ABS_LEN bytes and relative ones REL_LEN bytes.
module cbu_next_pc #(
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 8,
    parameter int ABS_LEN = 3,
    parameter int REL_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jmp_valid,
    input  logic              jmp_rel,
    input  logic              taken,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic [OFF_W-1:0]  jmp_offset,
    output logic [ADDR_W-1:0] next_pc,
    output logic              next_pc_valid,
    output logic              jmp_taken
);

    logic [ADDR_W-1:0] seq_pc, rel_pc, sel_pc;

    // Form sequential and relative addresses and select one.
    always_comb begin
        seq_pc = pc + (jmp_rel ? ADDR_W'(REL_LEN) : ADDR_W'(ABS_LEN));
        rel_pc = pc + ADDR_W'(REL_LEN) + ADDR_W'({{(ADDR_W-OFF_W){jmp_offset[OFF_W-1]}}, jmp_offset});
        if (!taken)       sel_pc = seq_pc;
        else if (jmp_rel) sel_pc = rel_pc;
        else              sel_pc = jmp_target;
    end

    // Register the decision; the address holds between jumps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc       <= '0;
            next_pc_valid <= 1'b0;
            jmp_taken     <= 1'b0;
        end else begin
            next_pc_valid <= jmp_valid;
            jmp_taken     <= jmp_valid && taken;
            if (jmp_valid) next_pc <= sel_pc;
        end
    end

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_valid |=> next_pc_valid);

    // R12
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !jmp_valid |=> !next_pc_valid);

    // R12
    taken_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_taken |-> next_pc_valid);

    // R11
    not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid && !jmp_rel && !taken) |=> (next_pc == $past(pc) + ADDR_W'(ABS_LEN)));

endmodule

// File: rtl/cmp_branch_unit.sv
// Compare and conditional branch unit, top level.
// Assumes at most one jump per cycle; a jump sees flags from before its edge.
module cmp_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NREG    = 4,
    parameter int ADDR_W  = 16,
    parameter int ABS_LEN = 3,
    parameter int REL_LEN = 2,
    localparam int SEL_W  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG*DATA_W-1:0] regs_flat,
    input  logic                   cmp_valid,
    input  logic [SEL_W-1:0]       cmp_src_sel,
    input  logic                   cmp_opnd_const,
    input  logic [SEL_W-1:0]       cmp_opnd_sel,
    input  logic                   sgn_mode,
    input  logic                   alu_upd,
    input  logic                   alu_z,
    input  logic                   alu_c,
    input  logic                   alu_n,
    input  logic                   alu_v,
    input  logic                   jmp_valid,
    input  logic [2:0]             jmp_cond,
    input  logic                   jmp_rel,
    input  logic [ADDR_W-1:0]      pc,
    input  logic [ADDR_W-1:0]      jmp_target,
    input  logic [DATA_W-1:0]      jmp_offset,
    output logic                   flag_z,
    output logic                   flag_c,
    output logic                   flag_n,
    output logic                   flag_v,
    output logic [ADDR_W-1:0]      next_pc,
    output logic                   next_pc_valid,
    output logic                   jmp_taken
);

    flags_t flags_q;
    logic   cond_taken;

    cbu_flag_gen #(.DATA_W(DATA_W), .NREG(NREG)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .regs_flat     (regs_flat),
        .cmp_valid     (cmp_valid),
        .cmp_src_sel   (cmp_src_sel),
        .cmp_opnd_const(cmp_opnd_const),
        .cmp_opnd_sel  (cmp_opnd_sel),
        .sgn_mode      (sgn_mode),
        .alu_upd       (alu_upd),
        .alu_z         (alu_z),
        .alu_c         (alu_c),
        .alu_n         (alu_n),
        .alu_v         (alu_v),
        .flags_q       (flags_q)
    );

    cbu_cond_eval u_cond (
        .flags(flags_q),
        .cond (jmp_cond),
        .taken(cond_taken)
    );

    cbu_next_pc #(
        .ADDR_W (ADDR_W),
        .OFF_W  (DATA_W),
        .ABS_LEN(ABS_LEN),
        .REL_LEN(REL_LEN)
    ) u_npc (
        .clk          (clk),
        .rst_n        (rst_n),
        .jmp_valid    (jmp_valid),
        .jmp_rel      (jmp_rel),
        .taken        (cond_taken),
        .pc           (pc),
        .jmp_target   (jmp_target),
        .jmp_offset   (jmp_offset),
        .next_pc      (next_pc),
        .next_pc_valid(next_pc_valid),
        .jmp_taken    (jmp_taken)
    );

    // Expose the stored flags.
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_n = flags_q.n;
    assign flag_v = flags_q.v;

    // R8
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid && jmp_cond == 3'd0) |=> jmp_taken);

    // R8
    never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_valid && jmp_cond == 3'd7) |=> !jmp_taken);

endmodule

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] regs_flat;
    logic        cmp_valid, cmp_opnd_const, sgn_mode;
    logic [1:0]  cmp_src_sel, cmp_opnd_sel;
    logic        alu_upd, alu_z, alu_c, alu_n, alu_v;
    logic        jmp_valid, jmp_rel;
    logic [2:0]  jmp_cond;
    logic [15:0] pc, jmp_target;
    logic [7:0]  jmp_offset;
    logic        flag_z, flag_c, flag_n, flag_v;
    logic [15:0] next_pc;
    logic        next_pc_valid, jmp_taken;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cmp_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .regs_flat(regs_flat),
        .cmp_valid(cmp_valid), .cmp_src_sel(cmp_src_sel),
        .cmp_opnd_const(cmp_opnd_const), .cmp_opnd_sel(cmp_opnd_sel),
        .sgn_mode(sgn_mode), .alu_upd(alu_upd), .alu_z(alu_z),
        .alu_c(alu_c), .alu_n(alu_n), .alu_v(alu_v),
        .jmp_valid(jmp_valid), .jmp_cond(jmp_cond), .jmp_rel(jmp_rel),
        .pc(pc), .jmp_target(jmp_target), .jmp_offset(jmp_offset),
        .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v),
        .next_pc(next_pc), .next_pc_valid(next_pc_valid), .jmp_taken(jmp_taken)
    );

    // Vector: [9:8] src, [7] const, [6:5] opnd, [4] signed, [3:1] cond, [0] expected taken.
    // Registers: a=0x05, b=0x05, c=0x80, d=0x10.
    localparam int NVEC = 18;
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 2'd1, 1'b0, 3'd1, 1'b1},  // R6 a==b eq
        {2'd0, 1'b0, 2'd1, 1'b0, 3'd2, 1'b0},  // R6 a==b ne
        {2'd0, 1'b0, 2'd3, 1'b0, 3'd3, 1'b1},  // R6 5<16
        {2'd0, 1'b0, 2'd3, 1'b0, 3'd5, 1'b0},  // R6 5>16
        {2'd2, 1'b0, 2'd3, 1'b0, 3'd5, 1'b1},  // R6 128>16 unsigned
        {2'd2, 1'b0, 2'd3, 1'b1, 3'd3, 1'b1},  // R7 -128<16
        {2'd2, 1'b0, 2'd3, 1'b1, 3'd6, 1'b0},  // R7 -128>=16
        {2'd0, 1'b1, 2'd1, 1'b0, 3'd6, 1'b1},  // R2 5>=1
        {2'd0, 1'b1, 2'd2, 1'b0, 3'd3, 1'b1},  // R2 5<255 (-1 code)
        {2'd0, 1'b1, 2'd2, 1'b1, 3'd5, 1'b1},  // R7 5>-1
        {2'd0, 1'b1, 2'd0, 1'b0, 3'd4, 1'b0},  // R2 5<=0
        {2'd1, 1'b1, 2'd3, 1'b0, 3'd4, 1'b1},  // R2 5<=255
        {2'd3, 1'b0, 2'd0, 1'b1, 3'd4, 1'b0},  // R7 16<=5
        {2'd0, 1'b0, 2'd0, 1'b0, 3'd4, 1'b1},  // R6 a<=a
        {2'd0, 1'b0, 2'd0, 1'b0, 3'd7, 1'b0},  // R8 never
        {2'd0, 1'b0, 2'd0, 1'b0, 3'd0, 1'b1},  // R8 always
        {2'd2, 1'b1, 2'd1, 1'b1, 3'd3, 1'b1},  // R7 -128<1 with overflow
        {2'd2, 1'b1, 2'd1, 1'b0, 3'd3, 1'b0}   // R6 128<1 unsigned
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cmp(input logic [1:0] src, input logic isc, input logic [1:0] op, input logic sg);
        cmp_valid = 1'b1; cmp_src_sel = src; cmp_opnd_const = isc;
        cmp_opnd_sel = op; sgn_mode = sg;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic do_jmp(input logic [2:0] cnd, input logic rel, input logic [15:0] p,
                          input logic [15:0] tgt, input logic [7:0] off);
        jmp_valid = 1'b1; jmp_cond = cnd; jmp_rel = rel;
        pc = p; jmp_target = tgt; jmp_offset = off;
        @(negedge clk);
        jmp_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; regs_flat = {8'h10, 8'h80, 8'h05, 8'h05};
        cmp_valid = 0; cmp_src_sel = 0; cmp_opnd_const = 0; cmp_opnd_sel = 0; sgn_mode = 0;
        alu_upd = 0; alu_z = 0; alu_c = 0; alu_n = 0; alu_v = 0;
        jmp_valid = 0; jmp_cond = 0; jmp_rel = 0; pc = 0; jmp_target = 0; jmp_offset = 0;
        repeat (3) @(negedge clk);
        check("R1 flags", {flag_z, flag_c, flag_n, flag_v}, 0);
        check("R1 outputs", {next_pc, next_pc_valid, jmp_taken}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            do_cmp(VEC[i][9:8], VEC[i][7], VEC[i][6:5], VEC[i][4]);
            do_jmp(VEC[i][3:1], 1'b0, 16'h0100, 16'h1234, 8'h00);
            check("R6/R7/R8 taken", jmp_taken, VEC[i][0]);
            check("R9/R11 next_pc", next_pc, VEC[i][0] ? 16'h1234 : 16'h0103);
        end

        // R3 flag values: 0x80 - 0x01 = 0x7F overflow; 0x05 - 0x10 = 0xF5 borrow
        do_cmp(2'd2, 1'b1, 2'd1, 1'b1);
        check("R3 z c n v", {flag_z, flag_c, flag_n, flag_v}, 4'b0001);
        do_cmp(2'd0, 1'b0, 2'd3, 1'b0);
        check("R3 z c n v", {flag_z, flag_c, flag_n, flag_v}, 4'b0110);

        // R5 idle cycles keep flags
        repeat (3) @(negedge clk);
        check("R5 hold", {flag_z, flag_c, flag_n, flag_v}, 4'b0110);

        // R4 ALU carry drives the less condition
        alu_upd = 1; alu_z = 0; alu_c = 1; alu_n = 0; alu_v = 0; sgn_mode = 0;
        @(negedge clk); alu_upd = 0;
        check("R4 alu load", {flag_z, flag_c, flag_n, flag_v}, 4'b0100);
        do_jmp(3'd3, 1'b0, 16'h0050, 16'h0ABC, 8'h00);
        check("R4 lt after carry", {jmp_taken, next_pc}, {1'b1, 16'h0ABC});

        // R4 compare wins over ALU update in the same cycle
        alu_upd = 1; alu_c = 1; alu_n = 1;
        do_cmp(2'd0, 1'b0, 2'd1, 1'b0);
        alu_upd = 0;
        check("R4 priority", {flag_z, flag_c, flag_n, flag_v}, 4'b1000);

        // R10 relative targets
        do_jmp(3'd0, 1'b1, 16'h0200, 16'h0000, 8'hF0);
        check("R10 backward", next_pc, 16'h01F2);
        do_jmp(3'd0, 1'b1, 16'h0200, 16'h0000, 8'h10);
        check("R10 forward", next_pc, 16'h0212);
        do_jmp(3'd0, 1'b1, 16'h0001, 16'h0000, 8'hF0);
        check("R10 wrap", next_pc, 16'hFFF3);

        // R11 sequential forms and wrap
        do_jmp(3'd7, 1'b1, 16'h0200, 16'h0000, 8'h10);
        check("R11 rel not taken", next_pc, 16'h0202);
        do_jmp(3'd7, 1'b0, 16'hFFFF, 16'h1111, 8'h00);
        check("R11 abs wrap", next_pc, 16'h0002);

        // R12 single-cycle valid and taken
        do_jmp(3'd0, 1'b0, 16'h0000, 16'h4444, 8'h00);
        check("R12 pulse", {next_pc_valid, jmp_taken}, 2'b11);
        @(negedge clk);
        check("R12 idle", {next_pc_valid, jmp_taken, next_pc}, {2'b00, 16'h4444});

        // R1 reset again clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {flag_z, flag_c, flag_n, flag_v, next_pc}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule